// File: doc/BRIEF.md
# Mailbox FIFO register interface

The block is a memory-mapped mailbox through which service logic on the graphics side hands 32-bit messages to a CPU. Producers push words into an eight-entry first-in first-out queue through a ready/valid style push port. The CPU drains the queue through a 32-bit register interface. It can pop the oldest word, look at it without removing it, read an empty/full/level status word and set a configuration word that holds a data-available interrupt enable.

A level interrupt is raised while the queue holds data and the enable is set. A second mailbox, which carries traffic in the opposite direction, has only an occupancy counter here. The graphics side bumps that counter, and the CPU sees its state through a status register of its own.

Register reads answer one cycle after the request. Writes take effect at the same clock edge. Storage that holds no message always reads as the all-ones invalid-data sentinel.

Top module: `mbox_top`

## Requirements
- R1: After reset the queue is empty, the enable is clear, `irq` is 0, `in_ready` is 1, peek returns 0xFFFFFFFF and status reads 0x40000000.
- R2: A read at byte offset 0x80, 0x84, 0x88 or 0x8C returns the oldest stored word and removes it. Words leave in the order they were pushed.
- R3: A pop read while the queue is empty returns 0xFFFFFFFF and leaves the level and contents unchanged.
- R4: A read at 0x90 returns the oldest word without removing it. When the queue is empty it returns 0xFFFFFFFF, including right after the last word has been popped.
- R5: A read at 0x98 returns status: bit 31 = level equals depth (8), bit 30 = level is zero, bits 7:0 = level, all other bits 0.
- R6: A read at 0x9C returns config: bit 0 = interrupt enable, bit 4 = queue not empty, all other bits 0. A write at 0x9C loads bit 0 from write-data bit 0 and ignores every other write-data bit.
- R7: `irq` is 1 exactly when the enable is set and the queue is not empty. It follows the state from the cycle after each change.
- R8: `in_ready` is 1 while the queue holds fewer than 8 words. A push with `in_valid` while full is dropped and leaves level and contents unchanged.
- R9: A push and a pop read in the same cycle both take effect.
- R10: A read at 0xB8 returns the second mailbox status in the R5 format. Its level rises on `aux_push` when below 8 and falls on `aux_pop` when above 0, and both may occur in one cycle.
- R11: Reads at any other offset return 0 and writes to them change nothing. An access whose byte enables are not all ones, or whose address has bits 1:0 nonzero, returns 0 and has no effect.
- R12: `rd_valid` is 1 in the cycle after each accepted bus request (`bus_sel`), and `rd_data` holds that request's read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | 32 | Word to enqueue |
| in_ready | output | 1 | Queue has room |
| aux_push | input | 1 | Second mailbox gains an entry |
| aux_pop | input | 1 | Second mailbox loses an entry |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_be | input | 4 | Byte enables; all ones required |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Response valid |
| rd_data | output | 32 | Read response |
| irq | output | 1 | Data-available interrupt level |

## Verification
The queue is driven in three ways. Pushes alone up to and past full separate a correct full limit from an overflow. Pops alone down to and past empty expose a missing sentinel refill and an underflow. Mixed push and pop in the same cycle expose a write index that ignores the simultaneous shift.

Pops are issued at each of the four pop offsets to show that the whole offset range is decoded. Config writes with all-ones data show whether only the enable bit is writable. Partial byte enables and unsupported offsets separate a strict decoder from a loose one. A long pseudo-random stretch mixes all of these against a queue-based reference model compared every clock.

// File: rtl/mbox_pkg.sv
// Package: shared word type, register offsets and status-word builder for
// the mailbox. Assumes a 32-bit register interface with byte offsets.
package mbox_pkg;

    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t EMPTY_WORD = '1;

    localparam logic [7:0] OFF_POP_FIRST = 8'h80;
    localparam logic [7:0] OFF_POP_LAST  = 8'h8C;
    localparam logic [7:0] OFF_PEEK      = 8'h90;
    localparam logic [7:0] OFF_STATUS    = 8'h98;
    localparam logic [7:0] OFF_CONFIG    = 8'h9C;
    localparam logic [7:0] OFF_AUX_STAT  = 8'hB8;

    // Status layout: full flag, empty flag, level in the low byte.
    function automatic word_t make_status(input logic [7:0] lvl,
                                          input logic full,
                                          input logic empty);
        word_t s;
        s = '0;
        s[31] = full;
        s[30] = empty;
        s[7:0] = lvl;
        return s;
    endfunction

endpackage

// File: rtl/mbox_level.sv
// Module: occupancy counter of one mailbox. Accepts a push only when not
// full and a pop only when not empty; both may happen in one cycle.
// Assumes DEPTH >= 1.
module mbox_level #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          push_ok,
    output logic          pop_ok
);

    // Flags derived from the current level.
    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;

    // Level update: add accepted push, subtract accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            level <= level + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R10 / R8: the level never exceeds the depth.
    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R8: a push into a full mailbox with no pop leaves it full.
    a_r8_full_push_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(level)));

    // R3: a pop from an empty mailbox with no push leaves it empty.
    a_r3_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/mbox_queue.sv
// Module: shift-register queue of DEPTH words. Slot 0 holds the oldest
// word. A pop shifts every slot down by one and the top slot loads the
// all-ones sentinel, so every unused slot reads as the sentinel.
// Assumes the sentinel never needs to be distinguished from real data.
module mbox_queue #(
    parameter int DEPTH = 8,
    parameter int W = mbox_pkg::WORD_W,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic          push_ok;
    logic          pop_ok;
    logic [CW-1:0] wr_idx;
    logic [W-1:0]  slot [DEPTH];

    mbox_level #(.DEPTH(DEPTH)) u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (pop),
        .level  (level),
        .full   (full),
        .empty  (empty),
        .push_ok(push_ok),
        .pop_ok (pop_ok)
    );

    // Write position: first free slot after any same-cycle shift.
    assign wr_idx = level - CW'(pop_ok);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] above;
        logic [W-1:0] nxt;

        if (i == DEPTH - 1) begin : g_top
            assign above = {W{1'b1}};
        end else begin : g_mid
            assign above = slot[i+1];
        end

        // Next value: shift on pop, then overlay an accepted push.
        always_comb begin
            nxt = pop_ok ? above : slot[i];
            if (push_ok && (wr_idx == CW'(i))) begin
                nxt = push_data;
            end
        end

        // Slot register, sentinel on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= {W{1'b1}};
            end else begin
                slot[i] <= nxt;
            end
        end
    end

    assign head = slot[0];

    if (DEPTH > 1) begin : g_chk_order
        // R2: a plain pop brings the second-oldest word to the head.
        a_r2_pop_order: assert property (@(posedge clk) disable iff (!rst_n)
            (pop && !empty && !push) |=> (head == $past(slot[1])));
    end

    // R4: popping the only word leaves the sentinel at the head.
    a_r4_freed_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == CW'(1)) |=> (head == {W{1'b1}}));

endmodule

// File: rtl/mbox_regs.sv
// Module: register decode, read mux, config register and interrupt.
// Answers every request one cycle later. Assumes 8-bit byte offsets,
// word-aligned full-width accesses and a level that fits in 8 bits.
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [3:0]    bus_be,
    input  word_t         bus_wdata,
    input  word_t         head,
    input  logic [CW-1:0] level,
    input  logic          full,
    input  logic          empty,
    input  logic [CW-1:0] aux_level,
    input  logic          aux_full,
    input  logic          aux_empty,
    output logic          pop,
    output logic          rd_valid,
    output word_t         rd_data,
    output logic          irq
);

    logic  acc_ok;
    logic  in_pop_range;
    logic  cfg_en;
    word_t rd_next;
    word_t cfg_word;

    // Access qualification: full byte enables and word alignment.
    assign acc_ok       = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
    assign in_pop_range = (bus_addr >= OFF_POP_FIRST) && (bus_addr <= OFF_POP_LAST);
    assign pop          = acc_ok && !bus_wr && in_pop_range;

    // Config view: enable bit plus live not-empty flag.
    always_comb begin
        cfg_word    = '0;
        cfg_word[0] = cfg_en;
        cfg_word[4] = ~empty;
    end

    // Read mux: pick the register addressed by a qualified read.
    always_comb begin
        rd_next = '0;
        if (acc_ok && !bus_wr) begin
            if (in_pop_range) begin
                rd_next = empty ? EMPTY_WORD : head;
            end else begin
                case (bus_addr)
                    OFF_PEEK:     rd_next = head;
                    OFF_STATUS:   rd_next = make_status(8'(level), full, empty);
                    OFF_CONFIG:   rd_next = cfg_word;
                    OFF_AUX_STAT: rd_next = make_status(8'(aux_level), aux_full, aux_empty);
                    default:      rd_next = '0;
                endcase
            end
        end
    end

    // Response register: one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= bus_sel;
            rd_data  <= rd_next;
        end
    end

    // Config enable: only bit 0 of a qualified config write is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en <= 1'b0;
        end else if (acc_ok && bus_wr && (bus_addr == OFF_CONFIG)) begin
            cfg_en <= bus_wdata[0];
        end
    end

    assign irq = cfg_en & ~empty;

    // R12: a response follows every request by exactly one cycle.
    a_r12_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_valid == $past(bus_sel)));

    // R6: a qualified config write stores write-data bit 0.
    a_r6_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be == 4'hF && bus_addr == OFF_CONFIG)
        |=> (cfg_en == $past(bus_wdata[0])));

    // R11: unqualified accesses never pop.
    a_r11_no_stray_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_be != 4'hF) |-> !pop);

endmodule

// File: rtl/mbox_top.sv
// Module: mailbox top. Producer-to-CPU queue with register access and a
// data-available interrupt, plus the occupancy counter of the opposite
// mailbox, whose status only is readable. Assumes synchronous reset.
module mbox_top
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    input  logic        aux_push,
    input  logic        aux_pop,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        irq
);

    localparam int CW = $clog2(DEPTH + 1);

    word_t         q_head;
    logic [CW-1:0] q_level;
    logic          q_full;
    logic          q_empty;
    logic          q_pop;
    logic [CW-1:0] a_level;
    logic          a_full;
    logic          a_empty;
    logic          a_push_ok;
    logic          a_pop_ok;

    mbox_queue #(.DEPTH(DEPTH), .W(WORD_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (in_valid),
        .push_data(in_data),
        .pop      (q_pop),
        .head     (q_head),
        .level    (q_level),
        .full     (q_full),
        .empty    (q_empty)
    );

    mbox_level #(.DEPTH(DEPTH)) u_aux (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (aux_push),
        .pop    (aux_pop),
        .level  (a_level),
        .full   (a_full),
        .empty  (a_empty),
        .push_ok(a_push_ok),
        .pop_ok (a_pop_ok)
    );

    mbox_regs #(.DEPTH(DEPTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .bus_wdata(bus_wdata),
        .head     (q_head),
        .level    (q_level),
        .full     (q_full),
        .empty    (q_empty),
        .aux_level(a_level),
        .aux_full (a_full),
        .aux_empty(a_empty),
        .pop      (q_pop),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    assign in_ready = ~q_full;

    // R7: the interrupt is never raised over an empty queue.
    a_r7_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !q_empty);

    // R10: the second mailbox moves by at most one per accepted event.
    a_r10_aux_step: assert property (@(posedge clk) disable iff (!rst_n)
        (a_push_ok && !a_pop_ok) |=> (a_level == $past(a_level) + CW'(1)));

endmodule

// File: tb/mbox_top_test.sv
// Bench: behavioural reference model (queue + counters) compared every clock.
module mbox_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        aux_push = 1'b0;
    logic        aux_pop = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mq[$];
    int          aux_n = 0;
    bit          m_en = 1'b0;

    mbox_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .aux_push(aux_push), .aux_pop(aux_pop),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] stat(int n);
        logic [31:0] s;
        s = 32'(n) & 32'hFF;
        if (n == 8) s[31] = 1'b1;
        if (n == 0) s[30] = 1'b1;
        return s;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive, advance model, compare after the edge.
    task automatic cyc(bit p, logic [31:0] pd, bit ap, bit apop,
                       bit sel, bit wr, logic [7:0] a, logic [3:0] be,
                       logic [31:0] wd, string tag);
        bit ok;
        bit popm;
        logic [31:0] exp_rd;
        int n;
        n = mq.size();
        ok = sel && be == 4'hF && a[1:0] == 2'b00;
        exp_rd = 32'h0;
        popm = 1'b0;
        if (ok && !wr) begin
            if (a >= 8'h80 && a <= 8'h8C) begin
                exp_rd = (n > 0) ? mq[0] : 32'hFFFF_FFFF;
                popm = (n > 0);
            end else if (a == 8'h90) exp_rd = (n > 0) ? mq[0] : 32'hFFFF_FFFF;
            else if (a == 8'h98) exp_rd = stat(n);
            else if (a == 8'h9C) exp_rd = {27'h0, (n > 0), 3'b000, m_en};
            else if (a == 8'hB8) exp_rd = stat(aux_n);
        end
        if (popm) void'(mq.pop_front());
        if (p && n < 8) mq.push_back(pd);
        if (ok && wr && a == 8'h9C) m_en = wd[0];
        begin
            int an;
            an = aux_n;
            if (ap && an < 8) aux_n++;
            if (apop && an > 0) aux_n--;
        end
        in_valid = p; in_data = pd; aux_push = ap; aux_pop = apop;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
        @(posedge clk);
        #2;
        check("R12 rd_valid", {31'h0, rd_valid}, {31'h0, sel});
        if (sel) check(tag, rd_data, exp_rd);
        check("R7 irq", {31'h0, irq}, {31'h0, (m_en && mq.size() > 0)});
        check("R8 in_ready", {31'h0, in_ready}, {31'h0, (mq.size() < 8)});
    endtask

    task automatic rd(logic [7:0] a, string tag);
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, a, 4'hF, 32'h0, tag);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, a, 4'hF, d, tag);
    endtask

    task automatic push(logic [31:0] d, string tag);
        cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 4'h0, 32'h0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 in_ready", {31'h0, in_ready}, 32'h1);
        check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        rd(8'h98, "R1 status");
        rd(8'h90, "R1 peek");
        rd(8'h9C, "R1 config");
        // R3: empty pop
        rd(8'h80, "R3 empty pop");
        rd(8'h98, "R3 status after empty pop");
        // R8 / R4 / R5
        push(32'h1111_0001, "R8 push");
        push(32'h2222_0002, "R8 push");
        push(32'h3333_0003, "R8 push");
        rd(8'h90, "R4 peek");
        rd(8'h90, "R4 peek again");
        rd(8'h98, "R5 status level 3");
        // R6 / R7
        wr(8'h9C, 32'hFFFF_FFFF, "R6 config write");
        rd(8'h9C, "R6 config read");
        // R2: pops at several offsets keep order
        rd(8'h84, "R2 pop 0x84");
        rd(8'h88, "R2 pop 0x88");
        rd(8'h8C, "R2 pop 0x8C");
        rd(8'h90, "R4 peek after drain");
        rd(8'h9C, "R6 config empty");
        // R8: fill and overflow
        for (int i = 0; i < 10; i++) push(32'hA000_0000 + 32'(i), "R8 fill");
        rd(8'h98, "R5 status full");
        rd(8'h80, "R2 pop after full");
        // R9: simultaneous push and pop
        cyc(1'b1, 32'hBEEF_0009, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 4'hF, 32'h0, "R9 push+pop");
        cyc(1'b1, 32'hBEEF_000A, 1'b0, 1'b0, 1'b1, 1'b0, 8'h98, 4'hF, 32'h0, "R9 status");
        for (int i = 0; i < 9; i++) rd(8'h80, "R2 drain");
        rd(8'h90, "R4 sentinel after drain");
        cyc(1'b1, 32'h5555_AAAA, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 4'hF, 32'h0, "R9 push+pop empty");
        rd(8'h90, "R9 peek");
        // R10: second mailbox
        for (int i = 0; i < 3; i++)
            cyc(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0, 4'h0, 32'h0, "R10 aux push");
        rd(8'hB8, "R10 aux status 3");
        for (int i = 0; i < 7; i++)
            cyc(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0, 4'h0, 32'h0, "R10 aux fill");
        rd(8'hB8, "R10 aux status full");
        cyc(1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hB8, 4'hF, 32'h0, "R10 aux both");
        rd(8'hB8, "R10 aux after both");
        // R11: unsupported offsets, partial enables, misaligned
        rd(8'hA0, "R11 unsupported read");
        wr(8'h98, 32'h0, "R11 write status");
        wr(8'h80, 32'h0, "R11 write pop offset");
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 4'h3, 32'h0, "R11 partial be pop");
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 4'hF, 32'h0, "R11 misaligned pop");
        cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h9C, 4'h1, 32'h0, "R11 partial cfg write");
        rd(8'h98, "R11 status unchanged");
        rd(8'h9C, "R11 config unchanged");
        // Mixed pseudo-random traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [7:0] addrs [8];
            int k;
            addrs = '{8'h80, 8'h84, 8'h8C, 8'h90, 8'h98, 8'h9C, 8'hB8, 8'hA4};
            k = int'($urandom % 8);
            cyc(($urandom % 3) != 0, $urandom, ($urandom % 2) == 1, ($urandom % 2) == 1,
                ($urandom % 4) != 0, ($urandom % 8) == 0, addrs[k],
                (($urandom % 10) == 0) ? 4'h7 : 4'hF, $urandom, "R2 R5 R6 R9 mixed");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule